// File: doc/BRIEF.md
# Peripheral Clock Prescaler Bank

The prescaler bank turns the raw clock sources of a microcontroller into the count-source enables that the serial I/O and timer blocks consume. Every source arrives as a single-cycle tick that is synchronous to the fabric clock `clk`. Every output is also a single-cycle tick, registered once, so it appears in the cycle after the source tick that caused it.

Three fixed taps divide a shared peripheral source by 1, 8 and 32. That source is either the main clock, or the PLL clock when PLL mode is on, or the on-chip oscillator. A fourth tap divides its own source by twice a 4-bit value `n`. When `n` is 0 this tap passes every tick through. Its source can be the peripheral source, the main oscillator input or the on-chip oscillator.

In wait mode with the stop flag set, every tap is silenced and its count is frozen. Low-power mode silences only the undivided tap. A change of source selection restarts the affected counters from zero.

Top module: `pclk_prescaler_bank`

## Requirements
- R1: The fixed-tap source is `main_tick` when `fix_src_sel`=0 and `pll_mode`=0, `pll_tick` when `fix_src_sel`=0 and `pll_mode`=1, and `osc_tick` when `fix_src_sel`=1. Ticks on unselected sources have no effect on the fixed taps.
- R2: `tick_d1` is high in the cycle after each selected fixed-source tick.
- R3: `tick_d8` and `tick_d32` pulse once per 8 and once per 32 fixed-source ticks. The first pulse follows the 8th or 32nd tick counted after reset or after a clear.
- R4: With `n`=0 the programmable tap `tick_d2n` pulses once for every tick of its source.
- R5: With `n`>0 the programmable tap pulses once per 2·n ticks of its source. The first pulse follows the 2n-th tick.
- R6: `prog_src_sel` picks the programmable source: 00 is the fixed-tap source, 01 is `xin_tick`, 10 is `osc_tick`, and 11 selects no source, so the tap stays idle.
- R7: While `stop_in_wait` and `wait_mode` are both 1, all four outputs stay low and the counters hold their counts. `wait_mode` alone has no effect.
- R8: `low_power`=1 holds `tick_d1` low and leaves the divided taps running.
- R9: A change of the fixed source selection clears the fixed counters. A change of the programmable source selection clears the programmable counter. No pulse comes from a partial period.
- R10: A new `div_n` value takes effect only after the current programmable period ends. Reset and source changes load it at once.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tick | input | 1 | Main clock source tick |
| pll_tick | input | 1 | PLL clock source tick |
| osc_tick | input | 1 | On-chip oscillator tick |
| xin_tick | input | 1 | Main oscillator input tick |
| pll_mode | input | 1 | Use PLL in place of main clock |
| fix_src_sel | input | 1 | Fixed source: 0 main/PLL, 1 on-chip oscillator |
| prog_src_sel | input | 2 | Programmable source select (see R6) |
| div_n | input | 4 | Programmable divide value n |
| stop_in_wait | input | 1 | Stop taps during wait mode |
| wait_mode | input | 1 | Device is in wait mode |
| low_power | input | 1 | Device is in low-power mode |
| tick_d1 | output | 1 | Fixed source divided by 1 |
| tick_d8 | output | 1 | Fixed source divided by 8 |
| tick_d32 | output | 1 | Fixed source divided by 32 |
| tick_d2n | output | 1 | Programmable tap output |

## Verification
The fixed taps are first driven with ticks on only one source at a time, in each of the three select settings. The pulse counts then show that the source is routed correctly and that the divide ratios are right. A flood of ticks on the unselected sources shows the mux leaks nothing.

The programmable tap is run with n of 0, 1, 2 and 3 and with each source code. A run of 2n−1 ticks followed by one more tick separates an exact period from an off-by-one. Changing n in the middle of a period separates a deferred reload from an immediate one.

Tick bursts split around a gated interval and around a select toggle show the difference between holding a count, losing a count and restarting from zero.

// File: rtl/pclk_pkg.sv
// Shared types for the peripheral prescaler bank.
// Assumes: nothing beyond IEEE 1800-2017.
package pclk_pkg;

    // Programmable tap source codes; values are visible at the port.
    typedef enum logic [1:0] {
        PSRC_PERIPH = 2'b00,
        PSRC_XIN    = 2'b01,
        PSRC_OSC    = 2'b10,
        PSRC_NONE   = 2'b11
    } psrc_e;

    localparam int unsigned NUM_FIX = 3;

endpackage

// File: rtl/pclk_src_mux.sv
// Source routing: picks the fixed-tap source tick and the programmable
// tap source tick from the raw source ticks.
// Assumes: all ticks are single-cycle pulses synchronous to the fabric clock.
module pclk_src_mux
    import pclk_pkg::*;
(
    input  logic  main_tick,
    input  logic  pll_tick,
    input  logic  osc_tick,
    input  logic  xin_tick,
    input  logic  pll_mode,
    input  logic  fix_src_sel,
    input  psrc_e prog_src_sel,
    output logic  fix_src,
    output logic  prog_src
);

    // Fixed-tap source: main or PLL, else on-chip oscillator.
    always_comb begin
        if (fix_src_sel)
            fix_src = osc_tick;
        else if (pll_mode)
            fix_src = pll_tick;
        else
            fix_src = main_tick;
    end

    // Programmable-tap source, three-way plus an idle code.
    always_comb begin
        unique case (prog_src_sel)
            PSRC_PERIPH: prog_src = fix_src;
            PSRC_XIN:    prog_src = xin_tick;
            PSRC_OSC:    prog_src = osc_tick;
            default:     prog_src = 1'b0;
        endcase
    end

endmodule

// File: rtl/pclk_sel_watch.sv
// Selection watcher: flags the cycle in which a source selection changes so
// the affected counters restart from zero.
// Assumes: select inputs are synchronous to the fabric clock.
module pclk_sel_watch
    import pclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pll_mode,
    input  logic  fix_src_sel,
    input  psrc_e prog_src_sel,
    output logic  fix_clear,
    output logic  prog_clear
);

    logic  prev_fix;
    logic  prev_pll;
    psrc_e prev_prog;

    // Remember the selection seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fix  <= fix_src_sel;
            prev_pll  <= pll_mode;
            prev_prog <= prog_src_sel;
        end else begin
            prev_fix  <= fix_src_sel;
            prev_pll  <= pll_mode;
            prev_prog <= prog_src_sel;
        end
    end

    // A PLL toggle only matters while the main/PLL branch is in use.
    always_comb begin
        fix_clear  = (fix_src_sel != prev_fix) ||
                     (!fix_src_sel && (pll_mode != prev_pll));
        prog_clear = (prog_src_sel != prev_prog) ||
                     ((prog_src_sel == PSRC_PERIPH) && fix_clear);
    end

endmodule

// File: rtl/pclk_fixed_div.sv
// Fixed-ratio tick divider: one output pulse per DIV accepted source ticks.
// Assumes: run low freezes the count; clear restarts it and drops the output.
module pclk_fixed_div #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_tick,
    input  logic run,
    input  logic clear,
    output logic tick
);

    generate
        if (DIV == 1) begin : g_pass
            // Pass every accepted tick through one register stage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tick <= 1'b0;
                else
                    tick <= src_tick && run && !clear;
            end
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            // Count accepted ticks and pulse on the last one of each period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else if (clear) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else if (run && src_tick) begin
                    tick <= (cnt == LAST);
                    cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end else begin
                    tick <= 1'b0;
                end
            end

            AST_FIX_TICK_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                tick |-> $past(src_tick && run && !clear)); // R3
            AST_FIX_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> !tick); // R9
            AST_FIX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !clear) |=> $stable(cnt)); // R7
        end
    endgenerate

endmodule

// File: rtl/pclk_prog_div.sv
// Programmable tick divider: one pulse per 2*n accepted ticks, every tick
// when n is zero. The active n is reloaded only at a period boundary.
// Assumes: run low freezes the count; clear restarts and reloads n.
module pclk_prog_div #(
    parameter int unsigned NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_tick,
    input  logic          run,
    input  logic          clear,
    input  logic [NW-1:0] div_n,
    output logic          tick
);

    localparam int unsigned CW = NW + 1;

    logic [NW-1:0] n_act;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          term;

    // Terminal count of the current period.
    always_comb begin
        last = {n_act, 1'b0} - 1'b1;
        term = (n_act == '0) || (cnt == last);
    end

    // Count, pulse at the terminal count and reload n there.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt   <= '0;
            n_act <= div_n;
            tick  <= 1'b0;
        end else if (run && src_tick) begin
            tick <= term;
            if (term) begin
                cnt   <= '0;
                n_act <= div_n;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    AST_PROG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((n_act == '0) && run && src_tick && !clear) |=> tick); // R4
    AST_PROG_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act != '0) |-> (cnt < {n_act, 1'b0})); // R5
    AST_PROG_N_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(run && src_tick && term)) |=> $stable(n_act)); // R10

endmodule

// File: rtl/pclk_prescaler_bank.sv
// Peripheral prescaler bank: three fixed taps over a shared peripheral source
// and one programmable 2n tap with its own source, all gated in wait mode.
// Assumes: all source inputs are single-cycle ticks synchronous to clk;
// outputs are registered one cycle after the causing source tick.
module pclk_prescaler_bank
    import pclk_pkg::*;
#(
    parameter int unsigned NW    = 4,
    parameter int unsigned DIV_A = 1,
    parameter int unsigned DIV_B = 8,
    parameter int unsigned DIV_C = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          main_tick,
    input  logic          pll_tick,
    input  logic          osc_tick,
    input  logic          xin_tick,
    input  logic          pll_mode,
    input  logic          fix_src_sel,
    input  logic [1:0]    prog_src_sel,
    input  logic [NW-1:0] div_n,
    input  logic          stop_in_wait,
    input  logic          wait_mode,
    input  logic          low_power,
    output logic          tick_d1,
    output logic          tick_d8,
    output logic          tick_d32,
    output logic          tick_d2n
);

    localparam int unsigned FIX_DIVS [NUM_FIX] = '{DIV_A, DIV_B, DIV_C};

    psrc_e              psel;
    logic               fix_src;
    logic               prog_src;
    logic               fix_clear;
    logic               prog_clear;
    logic               run;
    logic [NUM_FIX-1:0] fix_ticks;

    // Decode the raw select code and the wait-mode gate.
    always_comb begin
        psel = psrc_e'(prog_src_sel);
        run  = !(stop_in_wait && wait_mode);
    end

    pclk_src_mux i_mux (
        .main_tick    (main_tick),
        .pll_tick     (pll_tick),
        .osc_tick     (osc_tick),
        .xin_tick     (xin_tick),
        .pll_mode     (pll_mode),
        .fix_src_sel  (fix_src_sel),
        .prog_src_sel (psel),
        .fix_src      (fix_src),
        .prog_src     (prog_src)
    );

    pclk_sel_watch i_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_mode     (pll_mode),
        .fix_src_sel  (fix_src_sel),
        .prog_src_sel (psel),
        .fix_clear    (fix_clear),
        .prog_clear   (prog_clear)
    );

    generate
        for (genvar i = 0; i < NUM_FIX; i++) begin : g_fix
            // Only an undivided tap is also silenced by low-power mode.
            localparam bit LP_STOPS = (FIX_DIVS[i] == 1);
            logic tap_run;
            assign tap_run = LP_STOPS ? (run && !low_power) : run;

            pclk_fixed_div #(.DIV(FIX_DIVS[i])) i_div (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_tick (fix_src),
                .run      (tap_run),
                .clear    (fix_clear),
                .tick     (fix_ticks[i])
            );
        end
    endgenerate

    pclk_prog_div #(.NW(NW)) i_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (prog_src),
        .run      (run),
        .clear    (prog_clear),
        .div_n    (div_n),
        .tick     (tick_d2n)
    );

    // Name the fixed taps at the ports.
    always_comb begin
        tick_d1  = fix_ticks[0];
        tick_d8  = fix_ticks[1];
        tick_d32 = fix_ticks[2];
    end

    AST_WAIT_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_in_wait && wait_mode) |=> !(tick_d1 || tick_d8 || tick_d32 || tick_d2n)); // R7
    AST_LP_D1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> !tick_d1); // R8
    AST_SELCHG_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_src_sel != $past(fix_src_sel)) |=> !(tick_d8 || tick_d32)); // R9
    AST_D1_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tick_d1 |-> $past(main_tick || pll_tick || osc_tick)); // R2

endmodule

// File: tb/test_pclk_prescaler_bank.sv
// Directed bench for the peripheral prescaler bank.
module test_pclk_prescaler_bank;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] src_v;      // {xin, osc, pll, main}
    logic       pll_mode, fix_src_sel, stop_in_wait, wait_mode, low_power;
    logic [1:0] prog_src_sel;
    logic [3:0] div_n;
    logic       tick_d1, tick_d8, tick_d32, tick_d2n;

    int checks   = 0;
    int failures = 0;
    int c_d1 = 0, c_d8 = 0, c_d32 = 0, c_d2n = 0;

    localparam int MAIN = 0, PLL = 1, OSC = 2, XIN = 3;

    always #2 clk = ~clk;

    pclk_prescaler_bank i_pclk_prescaler_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_tick    (src_v[0]),
        .pll_tick     (src_v[1]),
        .osc_tick     (src_v[2]),
        .xin_tick     (src_v[3]),
        .pll_mode     (pll_mode),
        .fix_src_sel  (fix_src_sel),
        .prog_src_sel (prog_src_sel),
        .div_n        (div_n),
        .stop_in_wait (stop_in_wait),
        .wait_mode    (wait_mode),
        .low_power    (low_power),
        .tick_d1      (tick_d1),
        .tick_d8      (tick_d8),
        .tick_d32     (tick_d32),
        .tick_d2n     (tick_d2n)
    );

    // Pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (tick_d1)  c_d1++;
        if (tick_d8)  c_d8++;
        if (tick_d32) c_d32++;
        if (tick_d2n) c_d2n++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic zero();
        c_d1 = 0; c_d8 = 0; c_d32 = 0; c_d2n = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle();
        zero();
    endtask

    // Send num ticks on one source, one tick every two cycles.
    task automatic drive(input int which, input int num);
        for (int i = 0; i < num; i++) begin
            @(negedge clk) src_v[which] = 1'b1;
            @(negedge clk) src_v[which] = 1'b0;
        end
        settle();
    endtask

    task automatic set_sel(input logic fs, input logic pm, input logic [1:0] ps);
        @(negedge clk);
        fix_src_sel = fs; pll_mode = pm; prog_src_sel = ps;
        settle();
    endtask

    task automatic t_reset();
        reset_dut();
        chk("R11 outputs low", int'({tick_d1, tick_d8, tick_d32, tick_d2n}), 0);
        chk("R11 no pulses", c_d1 + c_d8 + c_d32 + c_d2n, 0);
    endtask

    task automatic t_main();
        drive(MAIN, 64);
        chk("R2 d1 main", c_d1, 64);
        chk("R3 d8 main", c_d8, 8);
        chk("R3 d32 main", c_d32, 2);
        zero();
        drive(PLL, 16);
        drive(OSC, 16);
        chk("R1 unselected ignored", c_d1 + c_d8 + c_d32, 0);
    endtask

    task automatic t_pll();
        set_sel(1'b0, 1'b1, 2'b11);
        zero();
        drive(PLL, 40);
        chk("R1 pll d1", c_d1, 40);
        chk("R1 pll d8", c_d8, 5);
        chk("R3 pll d32", c_d32, 1);
        zero();
        drive(MAIN, 10);
        chk("R1 main ignored in pll mode", c_d1, 0);
    endtask

    task automatic t_osc();
        set_sel(1'b1, 1'b0, 2'b11);
        zero();
        drive(OSC, 33);
        chk("R1 osc d1", c_d1, 33);
        chk("R3 osc d8", c_d8, 4);
        chk("R3 osc d32", c_d32, 1);
    endtask

    task automatic t_prog_bypass();
        div_n = 4'd0;
        set_sel(1'b0, 1'b0, 2'b01);
        reset_dut();
        drive(XIN, 7);
        chk("R4 n=0 xin", c_d2n, 7);
    endtask

    task automatic t_prog_div();
        div_n = 4'd3;
        set_sel(1'b0, 1'b0, 2'b10);
        reset_dut();
        drive(OSC, 5);
        chk("R5 n=3 before period end", c_d2n, 0);
        drive(OSC, 1);
        chk("R5 n=3 first pulse", c_d2n, 1);
        drive(OSC, 6);
        chk("R5 n=3 second pulse", c_d2n, 2);
        set_sel(1'b1, 1'b0, 2'b00);
        zero();
        drive(OSC, 6);
        chk("R6 peripheral source osc", c_d2n, 1);
        drive(MAIN, 6);
        chk("R6 peripheral ignores main", c_d2n, 1);
    endtask

    task automatic t_prog_none();
        set_sel(1'b0, 1'b0, 2'b11);
        zero();
        drive(MAIN, 10);
        drive(PLL, 10);
        drive(OSC, 10);
        drive(XIN, 10);
        chk("R6 idle code", c_d2n, 0);
    endtask

    task automatic t_wait();
        div_n = 4'd0;
        set_sel(1'b0, 1'b0, 2'b01);
        reset_dut();
        drive(MAIN, 5);
        chk("R7 pre-gate d8", c_d8, 0);
        wait_mode = 1'b1;
        drive(MAIN, 3);
        chk("R7 wait alone d8", c_d8, 1);
        chk("R7 wait alone d1", c_d1, 8);
        zero();
        stop_in_wait = 1'b1;
        drive(MAIN, 5);
        drive(XIN, 4);
        chk("R7 gated all quiet", c_d1 + c_d8 + c_d32 + c_d2n, 0);
        stop_in_wait = 1'b0;
        wait_mode = 1'b0;
        drive(MAIN, 3);
        chk("R7 count held (3 after gate)", c_d8, 0);
        drive(MAIN, 5);
        chk("R7 count held (8 after gate)", c_d8, 1);
    endtask

    task automatic t_lowpower();
        set_sel(1'b0, 1'b0, 2'b11);
        reset_dut();
        low_power = 1'b1;
        drive(MAIN, 16);
        chk("R8 d1 stopped", c_d1, 0);
        chk("R8 d8 runs", c_d8, 2);
        low_power = 1'b0;
    endtask

    task automatic t_selchg();
        reset_dut();
        drive(MAIN, 5);
        set_sel(1'b1, 1'b0, 2'b11);
        set_sel(1'b0, 1'b0, 2'b11);
        drive(MAIN, 7);
        chk("R9 restart no partial", c_d8, 0);
        drive(MAIN, 1);
        chk("R9 full period after clear", c_d8, 1);
    endtask

    task automatic t_nchange();
        div_n = 4'd2;
        set_sel(1'b0, 1'b0, 2'b01);
        reset_dut();
        drive(XIN, 2);
        div_n = 4'd1;
        drive(XIN, 2);
        chk("R10 old n finishes period", c_d2n, 1);
        drive(XIN, 4);
        chk("R10 new n after boundary", c_d2n, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_v = '0; pll_mode = 1'b0; fix_src_sel = 1'b0;
        prog_src_sel = 2'b11; div_n = 4'd0; stop_in_wait = 1'b0;
        wait_mode = 1'b0; low_power = 1'b0;
        t_reset();
        t_main();
        t_pll();
        t_osc();
        t_prog_bypass();
        t_prog_div();
        t_prog_none();
        t_wait();
        t_lowpower();
        t_selchg();
        t_nchange();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule